// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This block generates the reset line for a processor from three conditions: the supply settling after power-up, the supply sagging during operation, and the software failing to service a watchdog. A digital supply-good level comes from an external threshold comparator. Reset is held active while that level is low, and for a fixed stretch period after it returns high. After reset is released, a watchdog counter runs. Any falling edge on the chip-select line of the serial memory port restarts it. If software stops touching that line for longer than the selected interval, reset is asserted again for the same stretch period.

The interval is picked by a 2-bit code that comes from a nonvolatile setting outside the block. The block only reads this code and never changes it, so its value survives power cycles. A volatile cause bit tells software whether the most recent reset came from the watchdog or from a supply problem. Software can clear this bit with a one-cycle strobe. Whether the reset pin is active-low or active-high is fixed by a parameter. The `rst_n` input is the true power-on reset of the block's own logic. It is asserted asynchronously and is assumed to be released synchronously to `clk` by the surrounding logic.

Top module: `sup_reset_ctrl`

## Requirements
- R1: After `rst_n` is released with `supply_ok` high, or after `supply_ok` rises, the reset output deasserts exactly STRETCH_CYC+2 clock edges later. This count includes the two-flop synchronizer on the supply input.
- R2: A low level on `supply_ok` asserts the reset output at the third clock edge after the drop, and reset stays asserted while the level remains low.
- R3: If `supply_ok` drops again before the stretch period ends, the stretch restarts. Release then comes STRETCH_CYC+2 edges after the last rise.
- R4: If the watchdog is not restarted, reset asserts when the watchdog times out and is released STRETCH_CYC edges later.
- R5: `wdt_sel` selects the timeout: code 00 gives WDT_T0 cycles, 01 gives WDT_T1 and 10 gives WDT_T2.
- R6: Code 11 on `wdt_sel` disables the watchdog, and no watchdog reset occurs.
- R7: A falling edge on `cs_wdi_n` restarts the watchdog after a two-flop synchronizer. Timeout then comes WDT_Tn+3 edges after the fall. A rising edge does not restart the watchdog.
- R8: The watchdog counter is held at zero while reset is asserted. The timeout falls exactly WDT_Tn edges after the edge at which reset was released.
- R9: A watchdog timeout sets `wdt_cause` to 1.
- R10: `wdt_cause` reads 0 after a low-supply reset (from the edge where reset asserts) and after `rst_n` is asserted.
- R11: A one-cycle pulse on `cause_clr` clears `wdt_cause` at the next edge.
- R12: With ACTIVE_LOW=1, the reset output is 0 when asserted. With ACTIVE_LOW=0, it is 1 when asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset of the block logic, active low |
| supply_ok | input | 1 | Supply-good level from the external comparator |
| cs_wdi_n | input | 1 | Shared chip-select / watchdog restart line |
| wdt_sel | input | 2 | Watchdog interval code from the nonvolatile setting |
| cause_clr | input | 1 | Strobe that clears the cause bit |
| rst_out | output | 1 | Processor reset, polarity set by ACTIVE_LOW |
| wdt_cause | output | 1 | 1 when the last reset came from the watchdog |

## Verification
Each result has a fixed delay after its stimulus:
- Reset assertion on a supply drop comes three edges after the drop.
- Release comes STRETCH_CYC+2 edges after the last supply rise.
- Release after a watchdog reset comes STRETCH_CYC edges after the assertion.
- A watchdog timeout comes exactly the selected interval after release, or that interval plus three after a chip-select fall.

The bench records the cycle of each stimulus and queues every expected reset edge with its due cycle. A monitor samples shortly after each rising clock edge, and any change on the reset line must match the head of the queue in both level and cycle. The cause bit is read at fixed points: a few cycles after its setting or clearing event, and before the next such event.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Watchdog interval codes as held in the nonvolatile setting.
  typedef enum logic [1:0] {
    WSEL_SHORT = 2'b00,
    WSEL_MID   = 2'b01,
    WSEL_LONG  = 2'b10,
    WSEL_OFF   = 2'b11
  } wsel_e;

  // Width needed to count 0 .. n-1, at least one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/sup_kick_det.sv
module sup_kick_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic kick
);

  logic line_s;
  logic line_prev_q;

  // The line idles high, so both stages reset high and no false edge appears.
  sup_sync #(.RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(line_n),
    .q_sync (line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev_q <= 1'b1;
    end else begin
      line_prev_q <= line_s;
    end
  end

  assign kick = line_prev_q & ~line_s;

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned STRETCH_CYC = 16,
  parameter int unsigned SW          = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good,
  input  logic wdt_bite,
  output logic rst_act
);

  localparam logic [SW-1:0] LAST = SW'(STRETCH_CYC - 1);

  logic [SW-1:0] cnt_q;
  logic [SW-1:0] cnt_d;
  logic          act_q;
  logic          act_d;
  logic          cnt_en;

  // The counter only moves while reset is held with a good supply.
  assign cnt_en = act_q & supply_good & ~wdt_bite;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (!supply_good || wdt_bite) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign rst_act = act_q;

endmodule

// File: rtl/sup_wdt.sv
module sup_wdt
  import sup_pkg::*;
#(
  parameter int unsigned WDT_T0 = 30,
  parameter int unsigned WDT_T1 = 60,
  parameter int unsigned WDT_T2 = 120,
  parameter int unsigned CW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          kick,
  input  logic [1:0]    sel,
  output logic          bite,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] LIM0 = CW'(WDT_T0 - 1);
  localparam logic [CW-1:0] LIM1 = CW'(WDT_T1 - 1);
  localparam logic [CW-1:0] LIM2 = CW'(WDT_T2 - 1);

  wsel_e         sel_e;
  logic [CW-1:0] limit;
  logic          enabled;
  logic          clear;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign sel_e = wsel_e'(sel);

  always_comb begin
    enabled = 1'b1;
    limit   = LIM0;
    case (sel_e)
      WSEL_SHORT: limit = LIM0;
      WSEL_MID:   limit = LIM1;
      WSEL_LONG:  limit = LIM2;
      default: begin
        limit   = LIM2;
        enabled = 1'b0;
      end
    endcase
  end

  assign clear = hold | kick | ~enabled;
  assign bite  = ~clear & (cnt_q == limit);

  always_comb begin
    if (clear || bite) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int unsigned STRETCH_CYC = 4096,
  parameter int unsigned WDT_T0      = 20000,
  parameter int unsigned WDT_T1      = 100000,
  parameter int unsigned WDT_T2      = 400000,
  parameter bit          ACTIVE_LOW  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cs_wdi_n,
  input  logic [1:0] wdt_sel,
  input  logic       cause_clr,
  output logic       rst_out,
  output logic       wdt_cause
);

  localparam int unsigned SW     = sup_pkg::cnt_width(STRETCH_CYC);
  localparam int unsigned WMAX   = (WDT_T0 > WDT_T1) ?
                                   ((WDT_T0 > WDT_T2) ? WDT_T0 : WDT_T2) :
                                   ((WDT_T1 > WDT_T2) ? WDT_T1 : WDT_T2);
  localparam int unsigned WDT_CW = sup_pkg::cnt_width(WMAX);

  logic              supply_q;
  logic              kick;
  logic              bite;
  logic              rst_act;
  logic [WDT_CW-1:0] wdt_cnt;
  logic              cause_q;
  logic              cause_d;

  sup_sync #(.RST_VAL(1'b0)) u_supply_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(supply_ok),
    .q_sync (supply_q)
  );

  sup_kick_det u_kick (
    .clk   (clk),
    .rst_n (rst_n),
    .line_n(cs_wdi_n),
    .kick  (kick)
  );

  sup_wdt #(
    .WDT_T0(WDT_T0),
    .WDT_T1(WDT_T1),
    .WDT_T2(WDT_T2),
    .CW    (WDT_CW)
  ) u_wdt (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (rst_act),
    .kick (kick),
    .sel  (wdt_sel),
    .bite (bite),
    .count(wdt_cnt)
  );

  sup_stretch #(
    .STRETCH_CYC(STRETCH_CYC),
    .SW         (SW)
  ) u_stretch (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_good(supply_q),
    .wdt_bite   (bite),
    .rst_act    (rst_act)
  );

  // Low supply outranks a coincident timeout; a timeout outranks the clear strobe.
  always_comb begin
    cause_d = cause_q;
    if (!supply_q) begin
      cause_d = 1'b0;
    end else if (bite) begin
      cause_d = 1'b1;
    end else if (cause_clr) begin
      cause_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
    end else begin
      cause_q <= cause_d;
    end
  end

  assign wdt_cause = cause_q;

  generate
    if (ACTIVE_LOW) begin : g_pol_low
      assign rst_out = ~rst_act;
    end else begin : g_pol_high
      assign rst_out = rst_act;
    end
  endgenerate

endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
  parameter int unsigned CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_q,
  input logic          rst_act,
  input logic          bite,
  input logic          kick,
  input logic [CW-1:0] wdt_cnt,
  input logic [1:0]    wdt_sel,
  input logic          cause_clr,
  input logic          wdt_cause
);

  AST_LOW_SUPPLY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_q |=> rst_act);  // R2

  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_act) |-> $past(supply_q));  // R3

  AST_BITE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    bite && supply_q |=> rst_act && wdt_cause);  // R9

  AST_OFF_NO_BITE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_sel == 2'b11 |-> !bite);  // R6

  AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> wdt_cnt == '0);  // R7

  AST_HOLD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> wdt_cnt == '0);  // R8

  AST_LOW_SUPPLY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_q |=> !wdt_cause);  // R10

  AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cause_clr && !bite |=> !wdt_cause);  // R11

endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(.CW(WDT_CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .supply_q (supply_q),
  .rst_act  (rst_act),
  .bite     (bite),
  .kick     (kick),
  .wdt_cnt  (wdt_cnt),
  .wdt_sel  (wdt_sel),
  .cause_clr(cause_clr),
  .wdt_cause(wdt_cause)
);

// File: tb/sup_reset_ctrl_bench.sv
`timescale 1ns/1ps
module sup_reset_ctrl_bench;

  localparam int STR = 16;
  localparam int T0  = 30;
  localparam int T1  = 60;
  localparam int T2  = 120;

  typedef struct {
    int    stamp;
    bit    lvl;
    string req;
  } evt_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       cs_wdi_n;
  logic [1:0] wdt_sel;
  logic       cause_clr;
  logic       rst_out;
  logic       wdt_cause;
  logic       rst_out_hi;
  logic       wdt_cause_hi;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  bit   prev_act = 1'b1;
  evt_t expq[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  sup_reset_ctrl #(.STRETCH_CYC(STR), .WDT_T0(T0), .WDT_T1(T1), .WDT_T2(T2),
                   .ACTIVE_LOW(1'b1)) u_sup_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_wdi_n(cs_wdi_n),
    .wdt_sel(wdt_sel), .cause_clr(cause_clr), .rst_out(rst_out), .wdt_cause(wdt_cause)
  );

  sup_reset_ctrl #(.STRETCH_CYC(STR), .WDT_T0(T0), .WDT_T1(T1), .WDT_T2(T2),
                   .ACTIVE_LOW(1'b0)) u_sup_reset_ctrl_hi (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_wdi_n(cs_wdi_n),
    .wdt_sel(wdt_sel), .cause_clr(cause_clr), .rst_out(rst_out_hi), .wdt_cause(wdt_cause_hi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int stamp, input bit lvl, input string req);
    evt_t e;
    e.stamp = stamp;
    e.lvl   = lvl;
    e.req   = req;
    expq.push_back(e);
  endtask

  task automatic to_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: a change of the reset line must match the queue head.
  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      bit cur;
      cur = (rst_out == 1'b0);
      if (cur != prev_act) begin
        if (expq.size() == 0) begin
          chk(1'b0, "unexpected reset edge", int'(cur), int'(prev_act));
        end else begin
          evt_t e;
          e = expq.pop_front();
          chk(cur == e.lvl, e.req, int'(cur), int'(e.lvl));
          chk(cyc == e.stamp, e.req, cyc, e.stamp);
          // R12: the high-active variant mirrors the low-active one
          chk(rst_out_hi == cur, "R12", int'(rst_out_hi), int'(cur));
        end
      end
      prev_act = cur;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual=%0d expected=0 pending events", expq.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    int r;
    rst_n = 1'b0; supply_ok = 1'b1; cs_wdi_n = 1'b1; wdt_sel = 2'b11; cause_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(rst_out == 1'b0, "R12 reset state low-active", int'(rst_out), 0);
    chk(rst_out_hi == 1'b1, "R12 reset state high-active", int'(rst_out_hi), 1);
    chk(wdt_cause == 1'b0, "R10 reset state cause", int'(wdt_cause), 0);
    mon_en = 1'b1;

    // R1 power-on stretch
    s = cyc; rst_n = 1'b1;
    push(s + STR + 2, 1'b0, "R1 power-on release");

    // R6 disabled watchdog: long quiet window, monitor flags any edge
    to_cyc(s + STR + 2 + 3 * T2);
    chk(rst_out == 1'b1, "R6 disabled, no reset", int'(rst_out), 1);

    // R4/R8 code 00 timeout
    s = cyc; wdt_sel = 2'b00;
    push(s + T0, 1'b1, "R4 timeout T0");
    push(s + T0 + STR, 1'b0, "R4 release after timeout");
    r = s + T0 + STR;
    to_cyc(s + T0 + 5);
    chk(wdt_cause == 1'b1, "R9 cause after timeout", int'(wdt_cause), 1);

    // R5 code 01, changed during stretch, timed from release (R8)
    wdt_sel = 2'b01;
    push(r + T1, 1'b1, "R5 timeout T1");
    push(r + T1 + STR, 1'b0, "R5 release T1");
    r = r + T1 + STR;
    to_cyc(r - STR + 5);
    wdt_sel = 2'b10;
    push(r + T2, 1'b1, "R5 timeout T2");
    push(r + T2 + STR, 1'b0, "R5 release T2");
    r = r + T2 + STR;
    to_cyc(r - STR + 5);
    wdt_sel = 2'b00;

    // R7 restarts on falling edges only
    to_cyc(r + 10); cs_wdi_n = 1'b0;
    to_cyc(r + 12); cs_wdi_n = 1'b1;
    to_cyc(r + 20); cs_wdi_n = 1'b0;
    push(r + 20 + 3 + T0, 1'b1, "R7 timeout after last fall");
    push(r + 23 + T0 + STR, 1'b0, "R7 release");
    to_cyc(r + 35); cs_wdi_n = 1'b1;
    r = r + 23 + T0 + STR;
    to_cyc(r - STR + 5);
    wdt_sel = 2'b11;
    chk(wdt_cause == 1'b1, "R9 cause after restart test", int'(wdt_cause), 1);
    to_cyc(r + 5);

    // R2 low supply, R10 cause cleared, R3 glitch restarts stretch
    s = cyc; supply_ok = 1'b0;
    push(s + 3, 1'b1, "R2 low supply reset");
    to_cyc(s + 10);
    chk(wdt_cause == 1'b0, "R10 cause after low supply", int'(wdt_cause), 0);
    s = cyc; supply_ok = 1'b1;
    to_cyc(s + 5); supply_ok = 1'b0;
    to_cyc(s + 8); supply_ok = 1'b1;
    push(s + 8 + STR + 2, 1'b0, "R3 release after glitch");
    to_cyc(s + 8 + STR + 2 + 5);

    // Set cause again, then R10 power-on clear
    s = cyc; wdt_sel = 2'b00;
    push(s + T0, 1'b1, "R4 timeout before power-on");
    push(s + T0 + STR, 1'b0, "R4 release before power-on");
    to_cyc(s + T0 + 5); wdt_sel = 2'b11;
    to_cyc(s + T0 + STR + 5);
    chk(wdt_cause == 1'b1, "R9 cause set", int'(wdt_cause), 1);
    s = cyc; rst_n = 1'b0;
    push(s + 1, 1'b1, "R10 power-on assert");
    to_cyc(s + 2);
    chk(wdt_cause == 1'b0, "R10 cause after power-on", int'(wdt_cause), 0);
    s = cyc; rst_n = 1'b1;
    push(s + STR + 2, 1'b0, "R1 release after power-on");
    to_cyc(s + STR + 2 + 5);

    // R11 clear strobe
    s = cyc; wdt_sel = 2'b00;
    push(s + T0, 1'b1, "R4 timeout before clear");
    push(s + T0 + STR, 1'b0, "R4 release before clear");
    to_cyc(s + T0 + 5); wdt_sel = 2'b11;
    to_cyc(s + T0 + STR + 5);
    chk(wdt_cause == 1'b1, "R9 cause before clear", int'(wdt_cause), 1);
    cause_clr = 1'b1;
    @(negedge clk); cause_clr = 1'b0;
    chk(wdt_cause == 1'b0, "R11 cause after clear", int'(wdt_cause), 0);
    chk(wdt_cause_hi == 1'b0, "R11 cause after clear, second instance", int'(wdt_cause_hi), 0);

    to_cyc(cyc + 10);
    chk(expq.size() == 0, "all expected reset edges seen", expq.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule